// File: doc/BRIEF.md
# Burst Mode Register and Column Sequencer

This block keeps the programmable operating mode of a double-data-rate memory device and turns each read or write command into the column address of every data beat of the burst. A load-mode command carries an address word and bank bits. When it is legal, the block decodes three settings from it: the burst length, the beat ordering (sequential or interleaved) and the read latency. The decoded read latency is reported on an output so that the read data path can time its capture.

A read or write command carries a starting column. The sequencer then gives one column address per clock, for as many clocks as the burst length. The addresses stay inside an aligned block of columns whose size equals the burst length. A loaded setting stays in place until a new legal load, a deep power-down request or reset. Loads made while a bank is busy, loads with non-zero reserved bits or bank bits, and loads with reserved codes are all refused and reported on one-cycle flags.

Top module: `burst_col_seq`

## Requirements
- R1: After reset the mode is burst length 4, sequential ordering and read latency 3 (`burstLen`=4, `interleaved`=0, `readLatency`=3), and `beatValid` is low.
- R2: A legal load decodes `cmdAddr[2:0]` as burst length (001=2, 010=4, 011=8, 100=16), `cmdAddr[3]` as ordering (0 sequential, 1 interleaved) and `cmdAddr[6:4]` as read latency (010=2, 011=3). The new mode appears on the outputs in the cycle after the load edge.
- R3: A load made while `banksIdle` is low leaves the mode unchanged. It raises `loadReject` for exactly the one cycle after the load edge.
- R4: A load with any of `cmdAddr[12:7]` or `cmdBank` non-zero is ignored, and `loadIgnore` pulses for one cycle.
- R5: A load that carries a burst-length code or latency code not listed in R2 is ignored, the previous mode is kept, and `loadIgnore` pulses for one cycle.
- R6: `deepPd` puts the mode back to the R1 defaults and ends any burst in progress from the next cycle on.
- R7: A read (`rdCmd`) or write (`wrCmd`) registered at edge n gives `beatValid` high for exactly BL cycles after edge n, with `lastBeat` high only on the final beat.
- R8: In sequential mode, the low log2(BL) bits of beat i equal (start + i) mod BL.
- R9: In interleaved mode, the low log2(BL) bits of beat i equal start XOR i.
- R10: Column bits 8 down to log2(BL) of every beat equal those bits of the start column.
- R11: A read or write command that arrives during a burst abandons it. The next cycle shows beat 0 of the new burst, and a full BL beats follow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| loadMode | input | 1 | Load-mode command strobe |
| cmdAddr | input | 13 | Address word of the load-mode command |
| cmdBank | input | 2 | Bank bits of the load-mode command |
| banksIdle | input | 1 | High when every bank is idle |
| deepPd | input | 1 | Deep power-down request; clears the mode |
| rdCmd | input | 1 | Read command strobe |
| wrCmd | input | 1 | Write command strobe |
| colStart | input | 9 | Starting column of the read or write |
| colOut | output | 9 | Column address of the current beat |
| beatValid | output | 1 | A beat is being produced |
| lastBeat | output | 1 | The current beat is the final one |
| burstLen | output | 5 | Decoded burst length in beats |
| interleaved | output | 1 | 1 when interleaved ordering is selected |
| readLatency | output | 2 | Decoded read latency in clocks |
| loadReject | output | 1 | One-cycle pulse: load refused because a bank was busy |
| loadIgnore | output | 1 | One-cycle pulse: load refused for reserved bits or codes |

## Verification
The bench uses start columns whose low bits sit close to the block boundary. A sequencer that carries into bit log2(BL), or that masks with the wrong width, then walks into the neighbouring block. The interleaved runs use starts in which several low bits are set, because an adder used in place of XOR gives a different order there. Refused loads of each kind are followed by a read-back of the mode outputs, so a design that half-applies a reserved field or ignores `banksIdle` shows a changed setting. The abort and power-down cases expose a beat counter that is not restarted or a burst that keeps running after the mode is cleared.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

  // Decoded operating mode: blLog is log2 of the burst length.
  typedef struct packed {
    logic [2:0] blLog;
    logic       ilv;
    logic [1:0] lat;
  } modeT;

  localparam modeT MODE_RESET = '{blLog: 3'd2, ilv: 1'b0, lat: 2'd3};

  // Strobes from control to datapath.
  typedef struct packed {
    logic loadMode;
    logic clearMode;
    logic startBurst;
    logic stepBeat;
    modeT newMode;
  } strobeT;

endpackage

// File: rtl/bcs_ctrl.sv
module bcs_ctrl
  import bcs_pkg::*;
#(
  parameter int ADDR_W = 13,
  parameter int BANK_W = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadMode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              banksIdle,
  input  logic              deepPd,
  input  logic              rdCmd,
  input  logic              wrCmd,
  input  logic              atLast,
  output strobeT            stb,
  output logic              busy,
  output logic              loadReject,
  output logic              loadIgnore
);

  localparam int FIELD_TOP = 7;

  logic       blOk;
  logic       latOk;
  logic       resvZero;
  logic [2:0] blLogDec;
  logic [1:0] latDec;
  logic       loadTry;
  logic       loadLegal;
  logic       cmdGo;
  logic       rejNext;
  logic       ignNext;

  // Field decode of the load word
  always_comb begin
    blOk     = 1'b1;
    blLogDec = 3'd0;
    unique case (cmdAddr[2:0])
      3'b001:  blLogDec = 3'd1;
      3'b010:  blLogDec = 3'd2;
      3'b011:  blLogDec = 3'd3;
      3'b100:  blLogDec = 3'd4;
      default: blOk = 1'b0;
    endcase
    latOk  = 1'b1;
    latDec = 2'd0;
    unique case (cmdAddr[6:4])
      3'b010:  latDec = 2'd2;
      3'b011:  latDec = 2'd3;
      default: latOk = 1'b0;
    endcase
  end

  assign resvZero  = (cmdAddr[ADDR_W-1:FIELD_TOP] == '0) && (cmdBank == '0);
  assign loadTry   = loadMode && !deepPd;
  assign loadLegal = resvZero && blOk && latOk;
  assign rejNext   = loadTry && !banksIdle;
  assign ignNext   = loadTry && banksIdle && !loadLegal;
  assign cmdGo     = (rdCmd || wrCmd) && !deepPd;

  always_comb begin
    stb            = '0;
    stb.clearMode  = deepPd;
    stb.loadMode   = loadTry && banksIdle && loadLegal;
    stb.newMode    = '{blLog: blLogDec, ilv: cmdAddr[3], lat: latDec};
    stb.startBurst = cmdGo;
    stb.stepBeat   = busy && !atLast && !cmdGo && !deepPd;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      busy       <= 1'b0;
      loadReject <= 1'b0;
      loadIgnore <= 1'b0;
    end else begin
      loadReject <= rejNext;
      loadIgnore <= ignNext;
      if (deepPd)              busy <= 1'b0;
      else if (cmdGo)          busy <= 1'b1;
      else if (busy && atLast) busy <= 1'b0;
    end
  end

  AST_FLAGS_EXCL: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({loadReject, loadIgnore})); // R3
  AST_BUSY_ENDS: assert property (@(posedge clk) disable iff (!rstN)
    (busy && atLast && !rdCmd && !wrCmd) |=> !busy); // R7

endmodule

// File: rtl/bcs_dpath.sv
module bcs_dpath
  import bcs_pkg::*;
#(
  parameter int COL_W   = 9,
  parameter int MAX_LOG = 4
) (
  input  logic             clk,
  input  logic             rstN,
  input  strobeT           stb,
  input  logic [COL_W-1:0] colStart,
  output modeT             mode,
  output logic [COL_W-1:0] colOut,
  output logic             atLast
);

  localparam int BEAT_W = MAX_LOG;

  modeT              modeQ;
  logic [COL_W-1:0]  startQ;
  logic [BEAT_W-1:0] beatQ;
  logic [2:0]        blLogQ;
  logic              ilvQ;
  logic [COL_W-1:0]  mask;
  logic [COL_W-1:0]  beatExt;
  logic [COL_W-1:0]  seqCol;
  logic [COL_W-1:0]  ilvCol;

  // Mode register
  always_ff @(posedge clk) begin
    if (!rstN)              modeQ <= MODE_RESET;
    else if (stb.clearMode) modeQ <= MODE_RESET;
    else if (stb.loadMode)  modeQ <= stb.newMode;
  end

  // Burst state: start column, beat index and a snapshot of the mode
  always_ff @(posedge clk) begin
    if (!rstN) begin
      startQ <= '0;
      beatQ  <= '0;
      blLogQ <= MODE_RESET.blLog;
      ilvQ   <= 1'b0;
    end else if (stb.startBurst) begin
      startQ <= colStart;
      beatQ  <= '0;
      blLogQ <= modeQ.blLog;
      ilvQ   <= modeQ.ilv;
    end else if (stb.stepBeat) begin
      beatQ  <= beatQ + 1'b1;
    end
  end

  // Wrap mask: one bit set for each low column bit inside the block
  for (genvar b = 0; b < COL_W; b++) begin : g_mask
    assign mask[b] = (32'(blLogQ) > b);
  end

  assign beatExt = COL_W'(beatQ);
  assign seqCol  = startQ + beatExt;
  assign ilvCol  = startQ ^ beatExt;
  assign colOut  = (startQ & ~mask) | ((ilvQ ? ilvCol : seqCol) & mask);
  assign atLast  = (beatExt == mask);
  assign mode    = modeQ;

  AST_BLOCK_FIXED: assert property (@(posedge clk) disable iff (!rstN)
    $past(stb.stepBeat) |-> ((colOut & ~mask) == ($past(colOut) & ~mask))); // R10
  AST_SEQ_STEP: assert property (@(posedge clk) disable iff (!rstN)
    ($past(stb.stepBeat) && !ilvQ) |-> ((colOut & mask) == (($past(colOut) + 1'b1) & mask))); // R8
  AST_START_BEAT: assert property (@(posedge clk) disable iff (!rstN)
    stb.startBurst |=> (colOut == $past(colStart))); // R11

endmodule

// File: rtl/burst_col_seq.sv
module burst_col_seq
  import bcs_pkg::*;
#(
  parameter int ADDR_W  = 13,
  parameter int BANK_W  = 2,
  parameter int COL_W   = 9,
  parameter int MAX_LOG = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              loadMode,
  input  logic [ADDR_W-1:0] cmdAddr,
  input  logic [BANK_W-1:0] cmdBank,
  input  logic              banksIdle,
  input  logic              deepPd,
  input  logic              rdCmd,
  input  logic              wrCmd,
  input  logic [COL_W-1:0]  colStart,
  output logic [COL_W-1:0]  colOut,
  output logic              beatValid,
  output logic              lastBeat,
  output logic [MAX_LOG:0]  burstLen,
  output logic              interleaved,
  output logic [1:0]        readLatency,
  output logic              loadReject,
  output logic              loadIgnore
);

  strobeT stb;
  modeT   mode;
  logic   busy;
  logic   atLast;

  bcs_ctrl #(.ADDR_W(ADDR_W), .BANK_W(BANK_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .loadMode(loadMode), .cmdAddr(cmdAddr),
    .cmdBank(cmdBank), .banksIdle(banksIdle), .deepPd(deepPd),
    .rdCmd(rdCmd), .wrCmd(wrCmd), .atLast(atLast), .stb(stb),
    .busy(busy), .loadReject(loadReject), .loadIgnore(loadIgnore)
  );

  bcs_dpath #(.COL_W(COL_W), .MAX_LOG(MAX_LOG)) u_dpath (
    .clk(clk), .rstN(rstN), .stb(stb), .colStart(colStart),
    .mode(mode), .colOut(colOut), .atLast(atLast)
  );

  assign beatValid   = busy;
  assign lastBeat    = busy && atLast;
  assign burstLen    = (MAX_LOG+1)'(1) << mode.blLog;
  assign interleaved = mode.ilv;
  assign readLatency = mode.lat;

  AST_LAT_LEGAL: assert property (@(posedge clk) disable iff (!rstN)
    (readLatency == 2'd2) || (readLatency == 2'd3)); // R2
  AST_LAST_VALID: assert property (@(posedge clk) disable iff (!rstN)
    lastBeat |-> beatValid); // R7
  AST_MODE_HOLD: assert property (@(posedge clk) disable iff (!rstN)
    !$stable({burstLen, interleaved, readLatency}) |->
      ($past(loadMode && banksIdle) || $past(deepPd))); // R3
  AST_PD_STOPS: assert property (@(posedge clk) disable iff (!rstN)
    deepPd |=> !beatValid); // R6

endmodule

// File: tb/burst_col_seq_test.sv
`timescale 1ns/1ps
module burst_col_seq_test;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        loadMode = 1'b0;
  logic [12:0] cmdAddr = '0;
  logic [1:0]  cmdBank = '0;
  logic        banksIdle = 1'b1;
  logic        deepPd = 1'b0;
  logic        rdCmd = 1'b0;
  logic        wrCmd = 1'b0;
  logic [8:0]  colStart = '0;
  logic [8:0]  colOut;
  logic        beatValid, lastBeat, interleaved, loadReject, loadIgnore;
  logic [4:0]  burstLen;
  logic [1:0]  readLatency;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  burst_col_seq uut (
    .clk(clk), .rstN(rstN), .loadMode(loadMode), .cmdAddr(cmdAddr),
    .cmdBank(cmdBank), .banksIdle(banksIdle), .deepPd(deepPd),
    .rdCmd(rdCmd), .wrCmd(wrCmd), .colStart(colStart), .colOut(colOut),
    .beatValid(beatValid), .lastBeat(lastBeat), .burstLen(burstLen),
    .interleaved(interleaved), .readLatency(readLatency),
    .loadReject(loadReject), .loadIgnore(loadIgnore)
  );

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int expCol(int s, int bl, bit ilv, int i);
    int m = bl - 1;
    int low = ilv ? (s ^ i) : (s + i);
    return (s & ~m & 9'h1FF) | (low & m);
  endfunction

  task automatic chkMode(string req, int bl, int ilv, int lat);
    chk({req, " burstLen"}, burstLen, bl);
    chk({req, " interleaved"}, interleaved, ilv);
    chk({req, " readLatency"}, readLatency, lat);
  endtask

  // Load-mode command; samples the flags just after the load edge
  task automatic doLoad(logic [12:0] a, logic [1:0] bk, logic idle);
    @(negedge clk);
    loadMode = 1'b1; cmdAddr = a; cmdBank = bk; banksIdle = idle;
    @(posedge clk); #1;
    loadMode = 1'b0; cmdAddr = '0; cmdBank = '0; banksIdle = 1'b1;
  endtask

  // Issues a command and checks beats; abortAfter>0 stops early
  task automatic runBurst(string req, int start, int bl, bit ilv, bit wr, int abortAfter);
    int n = (abortAfter > 0) ? abortAfter : bl;
    @(negedge clk);
    colStart = 9'(start);
    if (wr) wrCmd = 1'b1; else rdCmd = 1'b1;
    @(posedge clk); #1;
    rdCmd = 1'b0; wrCmd = 1'b0;
    for (int i = 0; i < n; i++) begin
      chk({req, " col"}, colOut, expCol(start, bl, ilv, i));
      chk("R7 beatValid", beatValid, 1);
      chk("R7 lastBeat", lastBeat, (i == bl - 1) ? 1 : 0);
      if (i < n - 1 || abortAfter == 0) begin
        @(posedge clk); #1;
      end
    end
    if (abortAfter == 0) chk("R7 valid ends", beatValid, 0);
  endtask

  task automatic testReset();
    chkMode("R1", 4, 0, 3);
    chk("R1 beatValid", beatValid, 0);
    runBurst("R1 R8 default", 9'h07, 4, 0, 0, 0);
  endtask

  task automatic testSeq();
    doLoad(13'h023, 2'b00, 1'b1); // BL8 seq lat2
    chk("R2 no flags", loadReject | loadIgnore, 0);
    chkMode("R2", 8, 0, 2);
    runBurst("R8 R10 seq8", 9'h0F5, 8, 0, 0, 0);
    runBurst("R8 R10 seq8 write", 9'h1FF, 8, 0, 1, 0);
  endtask

  task automatic testIlv();
    doLoad(13'h03C, 2'b00, 1'b1); // BL16 ilv lat3
    chkMode("R2", 16, 1, 3);
    runBurst("R9 R10 ilv16", 9'h1A7, 16, 1, 0, 0);
    doLoad(13'h01A, 2'b00, 1'b1); // BL4 ilv lat... reserved lat 001 -> ignored
    chk("R5 ignore flag", loadIgnore, 1);
    chkMode("R5 kept", 16, 1, 3);
    doLoad(13'h02A, 2'b00, 1'b1); // BL4 ilv lat2
    chkMode("R2", 4, 1, 2);
    runBurst("R9 ilv4", 9'h0C6, 4, 1, 1, 0);
  endtask

  task automatic testBl2();
    doLoad(13'h031, 2'b00, 1'b1); // BL2 seq lat3
    chkMode("R2", 2, 0, 3);
    runBurst("R8 R10 seq2", 9'h13B, 2, 0, 0, 0);
  endtask

  task automatic testRefused();
    doLoad(13'h03C, 2'b00, 1'b0);
    chk("R3 reject flag", loadReject, 1);
    chk("R3 no ignore", loadIgnore, 0);
    chkMode("R3 kept", 2, 0, 3);
    @(posedge clk); #1;
    chk("R3 one-cycle pulse", loadReject, 0);
    doLoad(13'h223, 2'b00, 1'b1);
    chk("R4 ignore flag bit9", loadIgnore, 1);
    chkMode("R4 kept", 2, 0, 3);
    doLoad(13'h023, 2'b01, 1'b1);
    chk("R4 ignore flag bank", loadIgnore, 1);
    chk("R4 no reject", loadReject, 0);
    chkMode("R4 kept bank", 2, 0, 3);
    @(posedge clk); #1;
    chk("R4 one-cycle pulse", loadIgnore, 0);
    doLoad(13'h035, 2'b00, 1'b1); // BL code 101
    chk("R5 ignore flag bl", loadIgnore, 1);
    chkMode("R5 kept bl", 2, 0, 3);
    doLoad(13'h043, 2'b00, 1'b1); // latency code 100
    chk("R5 ignore flag lat", loadIgnore, 1);
    chkMode("R5 kept lat", 2, 0, 3);
  endtask

  task automatic testRestart();
    doLoad(13'h023, 2'b00, 1'b1); // BL8 seq lat2
    runBurst("R11 first", 9'h016, 8, 0, 0, 3);
    runBurst("R11 restart", 9'h04B, 8, 0, 1, 0);
  endtask

  task automatic testPowerDown();
    doLoad(13'h02C, 2'b00, 1'b1); // BL16 ilv lat2
    chkMode("R2", 16, 1, 2);
    runBurst("R6 pre", 9'h055, 16, 1, 0, 2);
    @(negedge clk);
    deepPd = 1'b1;
    @(posedge clk); #1;
    deepPd = 1'b0;
    chk("R6 burst ended", beatValid, 0);
    chkMode("R6 defaults", 4, 0, 3);
    runBurst("R6 R8 after", 9'h003, 4, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;
    testReset();
    testSeq();
    testIlv();
    testBl2();
    testRefused();
    testRestart();
    testPowerDown();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule